// File: doc/BRIEF.md
# Exception Priority Resolver

This block sits beside an instruction pipeline. For each instruction it receives a set of raised exception flags, one flag per event kind. It reduces that set to one winner and reports three things about it: the event code a handler would read, the address that fetch must jump to, and whether the winner belongs to the reset/abort class or to the general class. A valid strobe marks cycles that carry a winner.

Winners are ranked in two steps. The class comes first, and any reset/abort event outranks every general event. Inside a class, each event has an order number, and a lower number wins. When several events share an order number, the lower flag index wins. Reset/abort events always jump to one fixed address. General events jump to a programmable vector base plus an offset. A single debug-routing select can instead send a user break straight to a separate debug base. For the three data-side events, the code also depends on an access-direction input.

Top module: `exc_resolve`

## Requirements
- R1: All outputs are registered. They reflect the inputs sampled at the previous rising clock edge. `valid_o` is 1 exactly when at least one request bit was set. When no bit was set, `code_o`, `vaddr_o` and `abort_o` are all 0. Reset clears every output to 0.
- R2: A pending reset/abort event (request bits 0 to 4) wins over any pending general event (bits 5 to 17), whatever the order numbers are.
- R3: Reset/abort request bits are: 0 power-on reset, 1 manual reset, 2 debug-interface reset, 3 instruction TLB multi-hit, 4 data TLB multi-hit. Their ranking, from highest, is: bit 0, bit 2, bit 1, bit 3, bit 4. Codes: 0x000 for bits 0 and 2, 0x020 for bit 1, 0x140 for bits 3 and 4.
- R4: A reset/abort winner gives `vaddr_o` = 0xA000_0000 whatever the base inputs are, and sets `abort_o` to 1.
- R5: General request bits, listed with their order numbers (lower wins): 5 user break (0), 6 instruction address error (1), 7 instruction TLB miss (2), 8 instruction TLB protection (3), 9 general illegal, 10 slot illegal, 11 general FPU disable and 12 slot FPU disable (all 4), 13 data address error (5), 14 data TLB miss (6), 15 data TLB protection (7), 16 FPU exception (8), 17 initial page write (9).
- R6: Among the four events with order 4, the lower bit index wins, so bit 9 ranks above 10, 10 above 11, and 11 above 12.
- R7: A general winner sets `abort_o` to 0. Bits 7 and 14 give `vbase_i` + 0x400. Every other general bit gives `vbase_i` + 0x100, except a user break routed to the debug base (R8).
- R8: A user break gives code 0x1E0. When `dbg_route_i` is 1, `vaddr_o` equals `dbase_i` with no offset. When it is 0, `vaddr_o` is `vbase_i` + 0x100.
- R9: Data-side codes follow `wr_i` (0 = read, 1 = write): bit 13 gives 0x0E0 or 0x100, bit 14 gives 0x040 or 0x060, bit 15 gives 0x0A0 or 0x0C0.
- R10: Codes that do not depend on `wr_i`: bit 6 0x0E0, bit 7 0x040, bit 8 0x0A0, bit 9 0x180, bit 10 0x1A0, bit 11 0x800, bit 12 0x820, bit 16 0x120, bit 17 0x080.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | 18 | Pending event flags, one bit per event kind |
| wr_i | input | 1 | Access direction of the data-side event: 1 = write |
| vbase_i | input | ADDR_W | Vector base for general events |
| dbase_i | input | ADDR_W | Debug base for a routed user break |
| dbg_route_i | input | 1 | Sends a user break to the debug base |
| valid_o | output | 1 | A winner is reported this cycle |
| abort_o | output | 1 | The winner is in the reset/abort class |
| code_o | output | 12 | Event code of the winner |
| vaddr_o | output | ADDR_W | Target vector address |

## Verification
The first pattern raises each flag on its own, once per direction and once per routing setting. This separates the codes and address forms that depend on `wr_i` from those that do not, and it shows that reset targets ignore the bases. The second pattern raises every pair of flags. Pairs that cross the two classes show the class precedence. Pairs within a class expose any error in the order numbers or in the index tie-break among the order-4 group. An empty flag set and a reset-state sample show the idle encoding. Bases change between vectors, so a stale base or a base wrongly added to a reset target shows up.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int NUM_EV = 18;
    localparam int L1_N   = 5;
    localparam int CODE_W = 12;
    localparam int ORD_W  = 4;
    localparam int IDX_W  = $clog2(NUM_EV);
    localparam int KEY_W  = 1 + ORD_W + IDX_W;

    typedef enum logic [IDX_W-1:0] {
        EV_POR, EV_MRST, EV_DRST, EV_ITLB_MH, EV_DTLB_MH,
        EV_UBRK, EV_IADE, EV_ITLB_MISS, EV_ITLB_PROT,
        EV_GILL, EV_SILL, EV_GFPU, EV_SFPU,
        EV_DADE, EV_DTLB_MISS, EV_DTLB_PROT, EV_FPU, EV_IPW
    } ev_e;

    function automatic logic [ORD_W-1:0] ev_order(ev_e e);
        case (e)
            EV_POR, EV_DRST:                 return 4'd1;
            EV_MRST:                         return 4'd2;
            EV_ITLB_MH:                      return 4'd3;
            EV_DTLB_MH:                      return 4'd4;
            EV_UBRK:                         return 4'd0;
            EV_IADE:                         return 4'd1;
            EV_ITLB_MISS:                    return 4'd2;
            EV_ITLB_PROT:                    return 4'd3;
            EV_GILL, EV_SILL, EV_GFPU, EV_SFPU: return 4'd4;
            EV_DADE:                         return 4'd5;
            EV_DTLB_MISS:                    return 4'd6;
            EV_DTLB_PROT:                    return 4'd7;
            EV_FPU:                          return 4'd8;
            default:                         return 4'd9;
        endcase
    endfunction

    // lower key wins: class bit, then order, then index
    function automatic logic [KEY_W-1:0] ev_key(ev_e e);
        return {(int'(e) >= L1_N), ev_order(e), e};
    endfunction
endpackage

// File: rtl/exc_pick.sv
module exc_pick
    import exc_pkg::*;
(
    input  logic [NUM_EV-1:0] req,
    output logic              hit,
    output ev_e               win
);
    logic [KEY_W-1:0] best;

    always_comb begin
        hit  = 1'b0;
        win  = EV_POR;
        best = '1;
        for (int i = 0; i < NUM_EV; i++) begin
            if (req[i] && (!hit || ev_key(ev_e'(IDX_W'(i))) < best)) begin
                hit  = 1'b1;
                win  = ev_e'(IDX_W'(i));
                best = ev_key(ev_e'(IDX_W'(i)));
            end
        end
    end
endmodule

// File: rtl/exc_vector.sv
module exc_vector
    import exc_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] RST_VEC  = 32'hA000_0000,
    parameter logic [ADDR_W-1:0] GEN_OFS  = 'h100,
    parameter logic [ADDR_W-1:0] MISS_OFS = 'h400
) (
    input  ev_e               win,
    input  logic              wr,
    input  logic [ADDR_W-1:0] vbase,
    input  logic [ADDR_W-1:0] dbase,
    input  logic              route,
    output logic [CODE_W-1:0] code,
    output logic [ADDR_W-1:0] vaddr,
    output logic              abort
);
    always_comb begin
        case (win)
            EV_POR, EV_DRST:        code = 12'h000;
            EV_MRST:                code = 12'h020;
            EV_ITLB_MH, EV_DTLB_MH: code = 12'h140;
            EV_UBRK:                code = 12'h1E0;
            EV_IADE:                code = 12'h0E0;
            EV_ITLB_MISS:           code = 12'h040;
            EV_ITLB_PROT:           code = 12'h0A0;
            EV_GILL:                code = 12'h180;
            EV_SILL:                code = 12'h1A0;
            EV_GFPU:                code = 12'h800;
            EV_SFPU:                code = 12'h820;
            EV_DADE:                code = wr ? 12'h100 : 12'h0E0;
            EV_DTLB_MISS:           code = wr ? 12'h060 : 12'h040;
            EV_DTLB_PROT:           code = wr ? 12'h0C0 : 12'h0A0;
            EV_FPU:                 code = 12'h120;
            default:                code = 12'h080;
        endcase
    end

    always_comb begin
        abort = (int'(win) < L1_N);
        if (abort)
            vaddr = RST_VEC;
        else if (win == EV_UBRK && route)
            vaddr = dbase;
        else if (win == EV_ITLB_MISS || win == EV_DTLB_MISS)
            vaddr = vbase + MISS_OFS;
        else
            vaddr = vbase + GEN_OFS;
    end
endmodule

// File: rtl/exc_resolve.sv
module exc_resolve
    import exc_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] RST_VEC  = 32'hA000_0000,
    parameter logic [ADDR_W-1:0] GEN_OFS  = 'h100,
    parameter logic [ADDR_W-1:0] MISS_OFS = 'h400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_EV-1:0] req_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] vbase_i,
    input  logic [ADDR_W-1:0] dbase_i,
    input  logic              dbg_route_i,
    output logic              valid_o,
    output logic              abort_o,
    output logic [CODE_W-1:0] code_o,
    output logic [ADDR_W-1:0] vaddr_o
);
    typedef struct packed {
        logic              valid;
        logic              abort;
        logic [CODE_W-1:0] code;
        logic [ADDR_W-1:0] vaddr;
    } out_t;

    out_t              st_d, st_q;
    logic              hit;
    ev_e               win;
    logic [CODE_W-1:0] code_c;
    logic [ADDR_W-1:0] vaddr_c;
    logic              abort_c;

    exc_pick u_pick (
        .req (req_i),
        .hit (hit),
        .win (win)
    );

    exc_vector #(
        .ADDR_W   (ADDR_W),
        .RST_VEC  (RST_VEC),
        .GEN_OFS  (GEN_OFS),
        .MISS_OFS (MISS_OFS)
    ) u_vec (
        .win   (win),
        .wr    (wr_i),
        .vbase (vbase_i),
        .dbase (dbase_i),
        .route (dbg_route_i),
        .code  (code_c),
        .vaddr (vaddr_c),
        .abort (abort_c)
    );

    always_comb begin
        st_d = '0;
        if (hit) begin
            st_d.valid = 1'b1;
            st_d.abort = abort_c;
            st_d.code  = code_c;
            st_d.vaddr = vaddr_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o = st_q.valid;
    assign abort_o = st_q.abort;
    assign code_o  = st_q.code;
    assign vaddr_o = st_q.vaddr;
endmodule

// File: rtl/exc_resolve_chk.sv
module exc_resolve_chk
    import exc_pkg::*;
#(
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] RST_VEC  = 32'hA000_0000,
    parameter logic [ADDR_W-1:0] GEN_OFS  = 'h100,
    parameter logic [ADDR_W-1:0] MISS_OFS = 'h400
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_EV-1:0] req_i,
    input logic              wr_i,
    input logic [ADDR_W-1:0] vbase_i,
    input logic [ADDR_W-1:0] dbase_i,
    input logic              dbg_route_i,
    input logic              valid_o,
    input logic              abort_o,
    input logic [CODE_W-1:0] code_o,
    input logic [ADDR_W-1:0] vaddr_o
);
    localparam logic [NUM_EV-1:0] M_IPW   = NUM_EV'(1) << EV_IPW;
    localparam logic [NUM_EV-1:0] M_DMISS = NUM_EV'(1) << EV_DTLB_MISS;

    a_r1_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> valid_o == $past(|req_i));

    a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == '0) |=> (code_o == '0 && vaddr_o == '0 && !abort_o));

    a_r4_abort_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_i[L1_N-1:0]) |=> (abort_o && vaddr_o == RST_VEC));

    a_r8_debug_route: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i[EV_UBRK] && dbg_route_i && !(|req_i[L1_N-1:0]))
        |=> (code_o == 12'h1E0 && vaddr_o == $past(dbase_i)));

    a_r7_general_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == M_IPW) |=> (!abort_o && code_o == 12'h080 &&
                              vaddr_o == $past(vbase_i) + GEN_OFS));

    a_r9_dmiss_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i == M_DMISS) |=> (code_o == ($past(wr_i) ? 12'h060 : 12'h040) &&
                                vaddr_o == $past(vbase_i) + MISS_OFS));
endmodule

bind exc_resolve exc_resolve_chk #(
    .ADDR_W   (ADDR_W),
    .RST_VEC  (RST_VEC),
    .GEN_OFS  (GEN_OFS),
    .MISS_OFS (MISS_OFS)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (req_i),
    .wr_i        (wr_i),
    .vbase_i     (vbase_i),
    .dbase_i     (dbase_i),
    .dbg_route_i (dbg_route_i),
    .valid_o     (valid_o),
    .abort_o     (abort_o),
    .code_o      (code_o),
    .vaddr_o     (vaddr_o)
);

// File: tb/test_exc_resolve.sv
`timescale 1ns/1ps
module test_exc_resolve;
    localparam int N = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic          wr = 1'b0;
    logic [31:0]   vb = '0;
    logic [31:0]   db = '0;
    logic          rt = 1'b0;
    logic          valid_o, abort_o;
    logic [11:0]   code_o;
    logic [31:0]   vaddr_o;

    int checks = 0;
    int errs   = 0;
    bit done   = 0;

    typedef struct {
        logic        valid;
        logic        abort;
        logic [11:0] code;
        logic [31:0] addr;
        string       tag;
    } item_t;
    item_t q[$];

    always #2.5 clk = ~clk;

    exc_resolve i_exc_resolve (
        .clk(clk), .rst_n(rst_n), .req_i(req), .wr_i(wr),
        .vbase_i(vb), .dbase_i(db), .dbg_route_i(rt),
        .valid_o(valid_o), .abort_o(abort_o), .code_o(code_o), .vaddr_o(vaddr_o)
    );

    // ranking from highest: bit 0, 2, 1, then index order
    function automatic int rank_at(int p);
        if (p == 1) return 2;
        if (p == 2) return 1;
        return p;
    endfunction

    function automatic logic [11:0] exp_code(int e, bit w);
        case (e)
            0, 2:  return 12'h000;
            1:     return 12'h020;
            3, 4:  return 12'h140;
            5:     return 12'h1E0;
            6:     return 12'h0E0;
            7:     return 12'h040;
            8:     return 12'h0A0;
            9:     return 12'h180;
            10:    return 12'h1A0;
            11:    return 12'h800;
            12:    return 12'h820;
            13:    return w ? 12'h100 : 12'h0E0;
            14:    return w ? 12'h060 : 12'h040;
            15:    return w ? 12'h0C0 : 12'h0A0;
            16:    return 12'h120;
            default: return 12'h080;
        endcase
    endfunction

    task automatic send(logic [N-1:0] r, bit w, logic [31:0] b, logic [31:0] d,
                        bit route, string tag);
        item_t it;
        int    win = -1;
        @(negedge clk);
        req = r; wr = w; vb = b; db = d; rt = route;
        for (int p = 0; p < N; p++)
            if (win < 0 && r[rank_at(p)]) win = rank_at(p);
        it.tag = tag;
        if (win < 0) begin
            it.valid = 0; it.abort = 0; it.code = '0; it.addr = '0;
        end else begin
            it.valid = 1;
            it.abort = (win < 5);
            it.code  = exp_code(win, w);
            if (win < 5)                  it.addr = 32'hA000_0000;
            else if (win == 5 && route)   it.addr = d;
            else if (win == 7 || win == 14) it.addr = b + 32'h400;
            else                          it.addr = b + 32'h100;
        end
        q.push_back(it);
    endtask

    initial begin : monitor
        item_t it;
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                it = q.pop_front();
                checks++;
                if (valid_o !== it.valid || abort_o !== it.abort ||
                    code_o !== it.code || vaddr_o !== it.addr) begin
                    errs++;
                    $display("FAIL %s: got v=%b a=%b code=%h addr=%h, exp v=%b a=%b code=%h addr=%h",
                             it.tag, valid_o, abort_o, code_o, vaddr_o,
                             it.valid, it.abort, it.code, it.addr);
                end
            end
        end
    end

    initial begin : watchdog
        #(200000 * 5);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: got timeout, exp completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin : stim
        string tg;
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (valid_o !== 0 || abort_o !== 0 || code_o !== 0 || vaddr_o !== 0) begin
            errs++;
            $display("FAIL R1 reset: got v=%b a=%b code=%h addr=%h, exp all zero",
                     valid_o, abort_o, code_o, vaddr_o);
        end
        rst_n = 1'b1;
        // R1: idle with busy bases
        send('0, 1, 32'h1234_0000, 32'h5555_0000, 1, "R1");
        // every single event, both directions and routings
        for (int e = 0; e < N; e++)
            for (int k = 0; k < 4; k++) begin
                if (e < 5)                 tg = "R4";
                else if (e == 5)           tg = "R8";
                else if (e >= 13 && e <= 15) tg = "R9";
                else                       tg = "R10";
                send(N'(1) << e, k[0], 32'h8000_0000 + (e << 12) + (k << 20),
                     32'hC000_0000 + (e << 8), k[1], tg);
            end
        // R7: offsets for misses and plain general events
        send(N'(1) << 7,  0, 32'h0001_0000, 32'h0, 0, "R7");
        send(N'(1) << 14, 1, 32'hFFFF_F000, 32'h0, 1, "R7");
        send(N'(1) << 17, 0, 32'h0002_0000, 32'h0, 1, "R7");
        send(N'(1) << 16, 1, 32'h7FFF_FF00, 32'h0, 0, "R7");
        // pairs
        for (int a = 0; a < N; a++)
            for (int b = a + 1; b < N; b++) begin
                if ((a < 5) != (b < 5))        tg = "R2";
                else if (b < 5)                tg = "R3";
                else if (a >= 9 && b <= 12)    tg = "R6";
                else                           tg = "R5";
                send((N'(1) << a) | (N'(1) << b), 1'((a + b) & 1),
                     32'h4000_0000 + (a << 16) + (b << 8), 32'hE000_0000 + (a << 4),
                     1'(b & 1), tg);
            end
        // R2: all flags at once
        send('1, 1, 32'h9000_0000, 32'hA0A0_0000, 1, "R2");
        send('1 & ~N'(5'h1F), 1, 32'h9000_0000, 32'hA0A0_0000, 1, "R5");
        send('0, 0, 32'h0, 32'h0, 0, "R1");
        repeat (3) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule